// File: doc/BRIEF.md
# Handshaked Register Mailbox Endpoint

This block is the device end of a register mailbox. A host reaches it over a simple 32-bit register bus, and firmware logic inside the device reaches it through two ports. Two channels each own three registers: a control register, an address register and a data register. In each control register, valid and end flags pass ownership back and forth between host and device.

On the write channel, the host loads an address and raises address-valid. The device takes the address and clears the flag. The host then loads data, optionally raises data-end, and raises data-valid. The device presents that beat once on an internal write stream and clears both flags. On the read channel, the host loads an address and raises address-valid. The device issues one read request to firmware, and firmware answers with one or more beats. The device accepts one beat at a time into the read data register and raises data-valid, plus data-end on the last beat. The host reads the beat and acknowledges it by writing 1 to both flags.

A typical command is a command word written to target address 0, an optional parameter word also written to address 0, and then a one-beat read of a status word from address 0. Each channel has a small state machine. The write machine moves through W_IDLE, W_HOLD, W_TAKE_ADDR and W_EMIT. The read machine moves through R_IDLE, R_HOLD, R_ISSUE, R_FILL and R_HELD.

Write channel transitions:
- From W_IDLE, a raised address-valid or data-valid flag leads to W_HOLD, and address-valid has priority.
- W_HOLD waits TAKE_LAT cycles, then goes to W_TAKE_ADDR or W_EMIT.
- Both W_TAKE_ADDR and W_EMIT return to W_IDLE.

Read channel transitions:
- From R_IDLE, address-valid leads to R_HOLD, which waits TAKE_LAT cycles before R_ISSUE.
- R_ISSUE leads to R_FILL.
- R_FILL moves to R_HELD when a beat is accepted.
- R_HELD moves on when the host clears data-valid: to R_IDLE after the last beat, otherwise back to R_FILL.

Top module: `csr_mailbox_ep`

## Requirements
- R1: After reset, both control registers read 0, and fw_wr_valid, fw_rd_req and fw_rd_ready are low.
- R2: The register offsets are write control 0x20, write address 0x24, write data 0x28, read control 0x30, read address 0x34 and read data 0x38. In both control registers, bit 0 is address-valid, bit 1 is data-valid, bit 2 is data-end and bit 8 is overrun; all other bits read 0.
- R3: Once the host sets write address-valid, the device latches the write address register as the target of later beats and clears address-valid.
- R4: Once the host sets write data-valid, the device drives fw_wr_valid high for exactly one cycle. During that cycle fw_wr_addr is the latched target, fw_wr_data is the data register and fw_wr_last is data-end. The device then clears data-valid and data-end.
- R5: A write beat is taken no earlier than one cycle after its valid flag rises.
- R6: Writing 0 to a flag bit changes nothing. Writing 1 to a write-channel flag that is already set changes nothing. Writing 1 to read-channel data-valid or data-end while it is clear changes nothing.
- R7: A bus write to 0x24 or 0x34 while that channel's address-valid is set, or to 0x28 while write data-valid is set, leaves the register unchanged and sets that channel's overrun bit (bit 8). The bit stays set until the host writes 1 to bit 8 of the same control register.
- R8: Once the host sets read address-valid, the device pulses fw_rd_req for one cycle with fw_rd_addr equal to the read address register, and clears read address-valid.
- R9: A firmware beat is accepted when fw_rd_valid and fw_rd_ready are both high. Its data appears at 0x38, read data-valid becomes set, and data-end equals fw_rd_last. fw_rd_ready stays low while read data-valid is set.
- R10: The host writing 1 to bits 1 and 2 of 0x30 clears both flags. After a beat that was not the last, the device then accepts the next beat.
- R11: The read data register at 0x38 cannot be written by the host.
- R12: The full command sequence works end to end: command word to address 0, parameter word to address 0, then a one-beat status read from address 0.
- R13: bus_rdata takes the addressed register's value on the clock edge that samples bus_rd. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| fw_wr_valid | output | 1 | One-cycle write beat strobe |
| fw_wr_addr | output | 32 | Target address of the beat |
| fw_wr_data | output | 32 | Beat data |
| fw_wr_last | output | 1 | Beat is the last of its burst |
| fw_rd_req | output | 1 | One-cycle read request strobe |
| fw_rd_addr | output | 32 | Read target address |
| fw_rd_ready | output | 1 | Device can take a response beat |
| fw_rd_valid | input | 1 | Firmware response beat valid |
| fw_rd_data | input | 32 | Response beat data |
| fw_rd_last | input | 1 | Response beat is the last |

## Verification
The bench builds the block with TAKE_LAT = 3 and ADDR_W = 8. A hold of three cycles keeps each raised flag pending long enough for a back-to-back second register write to land while the flag is still set. That makes the overrun path and the ignored-write path reachable from plain bus timing. The bench's firmware model answers with one to three beats, which reaches the R_HELD to R_FILL loop and the ready blocking on multi-beat reads.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned REG_W = 32;

    localparam logic [7:0] OFF_WCTL  = 8'h20;
    localparam logic [7:0] OFF_WADDR = 8'h24;
    localparam logic [7:0] OFF_WDATA = 8'h28;
    localparam logic [7:0] OFF_RCTL  = 8'h30;
    localparam logic [7:0] OFF_RADDR = 8'h34;
    localparam logic [7:0] OFF_RDATA = 8'h38;

    localparam int unsigned FLG_AV  = 0;
    localparam int unsigned FLG_DV  = 1;
    localparam int unsigned FLG_DE  = 2;
    localparam int unsigned FLG_OVR = 8;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HOLD,
        W_TAKE_ADDR,
        W_EMIT
    } wr_state_e;

    typedef enum logic [2:0] {
        R_IDLE,
        R_HOLD,
        R_ISSUE,
        R_FILL,
        R_HELD
    } rd_state_e;

    function automatic logic [REG_W-1:0] ctl_word(input logic av, input logic dv,
                                                  input logic de, input logic ovr);
        logic [REG_W-1:0] w;
        w = '0;
        w[FLG_AV]  = av;
        w[FLG_DV]  = dv;
        w[FLG_DE]  = de;
        w[FLG_OVR] = ovr;
        return w;
    endfunction

endpackage

// File: rtl/mbx_hold_cnt.sv
module mbx_hold_cnt #(
    parameter int unsigned LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    generate
        if (LAT <= 1) begin : g_direct
            assign done = run;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run) begin
                    cnt <= '0;
                end else if (!done) begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign done = run && (cnt == CNT_W'(LAT - 1));
        end
    endgenerate
endmodule

// File: rtl/mbx_csr_decode.sv
module mbx_csr_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  wctl_val,
    input  logic [REG_W-1:0]  waddr_val,
    input  logic [REG_W-1:0]  wdata_val,
    input  logic [REG_W-1:0]  rctl_val,
    input  logic [REG_W-1:0]  raddr_val,
    input  logic [REG_W-1:0]  rdata_val,
    output logic              wctl_we,
    output logic              waddr_we,
    output logic              wdata_we,
    output logic              rctl_we,
    output logic              raddr_we,
    output logic [REG_W-1:0]  bus_rdata
);
    logic hit_wctl, hit_waddr, hit_wdata, hit_rctl, hit_raddr, hit_rdata;
    logic [REG_W-1:0] mux_val;

    assign hit_wctl  = (bus_addr == ADDR_W'(OFF_WCTL));
    assign hit_waddr = (bus_addr == ADDR_W'(OFF_WADDR));
    assign hit_wdata = (bus_addr == ADDR_W'(OFF_WDATA));
    assign hit_rctl  = (bus_addr == ADDR_W'(OFF_RCTL));
    assign hit_raddr = (bus_addr == ADDR_W'(OFF_RADDR));
    assign hit_rdata = (bus_addr == ADDR_W'(OFF_RDATA));

    assign wctl_we  = bus_wr && hit_wctl;
    assign waddr_we = bus_wr && hit_waddr;
    assign wdata_we = bus_wr && hit_wdata;
    assign rctl_we  = bus_wr && hit_rctl;
    assign raddr_we = bus_wr && hit_raddr;

    always_comb begin
        mux_val = '0;
        if (hit_wctl)  mux_val = wctl_val;
        if (hit_waddr) mux_val = waddr_val;
        if (hit_wdata) mux_val = wdata_val;
        if (hit_rctl)  mux_val = rctl_val;
        if (hit_raddr) mux_val = raddr_val;
        if (hit_rdata) mux_val = rdata_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= mux_val;
        end
    end
endmodule

// File: rtl/mbx_wr_chan.sv
module mbx_wr_chan
    import mbx_pkg::*;
#(
    parameter int unsigned TAKE_LAT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             addr_we,
    input  logic             data_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl_val,
    output logic [REG_W-1:0] addr_val,
    output logic [REG_W-1:0] data_val,
    output logic             av_flag,
    output logic             dv_flag,
    output logic             de_flag,
    output logic             ovr_flag,
    output logic             fw_wr_valid,
    output logic [REG_W-1:0] fw_wr_addr,
    output logic [REG_W-1:0] fw_wr_data,
    output logic             fw_wr_last
);
    wr_state_e        st, st_n;
    logic             pick_addr_q;
    logic [REG_W-1:0] addr_q, data_q, tgt_q;
    logic             hold_run, hold_done;
    logic             dev_take_addr, dev_emit;

    mbx_hold_cnt #(.LAT(TAKE_LAT)) i_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (hold_run),
        .done (hold_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= W_IDLE;
            pick_addr_q <= 1'b0;
        end else begin
            st <= st_n;
            if (st == W_IDLE) begin
                pick_addr_q <= av_flag;
            end
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            W_IDLE:      if (av_flag || dv_flag) st_n = W_HOLD;
            W_HOLD:      if (hold_done) st_n = pick_addr_q ? W_TAKE_ADDR : W_EMIT;
            W_TAKE_ADDR: st_n = W_IDLE;
            W_EMIT:      st_n = W_IDLE;
            default:     st_n = W_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        hold_run      = 1'b0;
        dev_take_addr = 1'b0;
        dev_emit      = 1'b0;
        unique case (st)
            W_IDLE:      ;
            W_HOLD:      hold_run = 1'b1;
            W_TAKE_ADDR: dev_take_addr = 1'b1;
            W_EMIT:      dev_emit = 1'b1;
            default:     ;
        endcase
    end

    // flags: a set flag falls only on device consumption, a clear flag rises only on host write of 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            av_flag  <= 1'b0;
            dv_flag  <= 1'b0;
            de_flag  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            av_flag <= av_flag ? !dev_take_addr : (ctl_we && wdata[FLG_AV]);
            dv_flag <= dv_flag ? !dev_emit      : (ctl_we && wdata[FLG_DV]);
            de_flag <= de_flag ? !dev_emit      : (ctl_we && wdata[FLG_DE]);
            if ((addr_we && av_flag) || (data_we && dv_flag)) begin
                ovr_flag <= 1'b1;
            end else if (ctl_we && wdata[FLG_OVR]) begin
                ovr_flag <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            tgt_q  <= '0;
        end else begin
            if (addr_we && !av_flag) addr_q <= wdata;
            if (data_we && !dv_flag) data_q <= wdata;
            if (dev_take_addr)       tgt_q  <= addr_q;
        end
    end

    assign ctl_val     = ctl_word(av_flag, dv_flag, de_flag, ovr_flag);
    assign addr_val    = addr_q;
    assign data_val    = data_q;
    assign fw_wr_valid = dev_emit;
    assign fw_wr_addr  = tgt_q;
    assign fw_wr_data  = data_q;
    assign fw_wr_last  = dev_emit && de_flag;
endmodule

// File: rtl/mbx_rd_chan.sv
module mbx_rd_chan
    import mbx_pkg::*;
#(
    parameter int unsigned TAKE_LAT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             addr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl_val,
    output logic [REG_W-1:0] addr_val,
    output logic [REG_W-1:0] data_val,
    output logic             av_flag,
    output logic             dv_flag,
    output logic             de_flag,
    output logic             ovr_flag,
    output logic             fw_rd_req,
    output logic [REG_W-1:0] fw_rd_addr,
    output logic             fw_rd_ready,
    input  logic             fw_rd_valid,
    input  logic [REG_W-1:0] fw_rd_data,
    input  logic             fw_rd_last
);
    rd_state_e        st, st_n;
    logic [REG_W-1:0] addr_q, rdat_q;
    logic             last_q;
    logic             hold_run, hold_done;
    logic             dev_issue, dev_fill, accept;
    logic             ack_dv, ack_de;

    mbx_hold_cnt #(.LAT(TAKE_LAT)) i_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (hold_run),
        .done (hold_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= R_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            R_IDLE:  if (av_flag) st_n = R_HOLD;
            R_HOLD:  if (hold_done) st_n = R_ISSUE;
            R_ISSUE: st_n = R_FILL;
            R_FILL:  if (fw_rd_valid) st_n = R_HELD;
            R_HELD:  if (!dv_flag) st_n = last_q ? R_IDLE : R_FILL;
            default: st_n = R_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        hold_run  = 1'b0;
        dev_issue = 1'b0;
        dev_fill  = 1'b0;
        unique case (st)
            R_IDLE:  ;
            R_HOLD:  hold_run = 1'b1;
            R_ISSUE: dev_issue = 1'b1;
            R_FILL:  dev_fill = 1'b1;
            R_HELD:  ;
            default: ;
        endcase
    end

    assign accept = dev_fill && fw_rd_valid;
    assign ack_dv = ctl_we && wdata[FLG_DV];
    assign ack_de = ctl_we && wdata[FLG_DE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            av_flag  <= 1'b0;
            dv_flag  <= 1'b0;
            de_flag  <= 1'b0;
            ovr_flag <= 1'b0;
            last_q   <= 1'b0;
            addr_q   <= '0;
            rdat_q   <= '0;
        end else begin
            av_flag <= av_flag ? !dev_issue : (ctl_we && wdata[FLG_AV]);
            dv_flag <= dv_flag ? !ack_dv    : accept;
            de_flag <= de_flag ? !ack_de    : (accept && fw_rd_last);
            if (addr_we && av_flag) begin
                ovr_flag <= 1'b1;
            end else if (ctl_we && wdata[FLG_OVR]) begin
                ovr_flag <= 1'b0;
            end
            if (addr_we && !av_flag) addr_q <= wdata;
            if (accept) begin
                rdat_q <= fw_rd_data;
                last_q <= fw_rd_last;
            end
        end
    end

    assign ctl_val     = ctl_word(av_flag, dv_flag, de_flag, ovr_flag);
    assign addr_val    = addr_q;
    assign data_val    = rdat_q;
    assign fw_rd_req   = dev_issue;
    assign fw_rd_addr  = addr_q;
    assign fw_rd_ready = dev_fill;
endmodule

// File: rtl/csr_mailbox_ep.sv
module csr_mailbox_ep
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned TAKE_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fw_wr_valid,
    output logic [31:0]       fw_wr_addr,
    output logic [31:0]       fw_wr_data,
    output logic              fw_wr_last,
    output logic              fw_rd_req,
    output logic [31:0]       fw_rd_addr,
    output logic              fw_rd_ready,
    input  logic              fw_rd_valid,
    input  logic [31:0]       fw_rd_data,
    input  logic              fw_rd_last
);
    logic             wctl_we, waddr_we, wdata_we, rctl_we, raddr_we;
    logic [REG_W-1:0] wctl_val, waddr_val, wdata_val;
    logic [REG_W-1:0] rctl_val, raddr_val, rdata_val;
    logic             wr_av, wr_dv, wr_de, wr_ovr;
    logic             rd_av, rd_dv, rd_de, rd_ovr;

    mbx_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wctl_val (wctl_val),
        .waddr_val(waddr_val),
        .wdata_val(wdata_val),
        .rctl_val (rctl_val),
        .raddr_val(raddr_val),
        .rdata_val(rdata_val),
        .wctl_we  (wctl_we),
        .waddr_we (waddr_we),
        .wdata_we (wdata_we),
        .rctl_we  (rctl_we),
        .raddr_we (raddr_we),
        .bus_rdata(bus_rdata)
    );

    mbx_wr_chan #(.TAKE_LAT(TAKE_LAT)) i_wr_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (wctl_we),
        .addr_we    (waddr_we),
        .data_we    (wdata_we),
        .wdata      (bus_wdata),
        .ctl_val    (wctl_val),
        .addr_val   (waddr_val),
        .data_val   (wdata_val),
        .av_flag    (wr_av),
        .dv_flag    (wr_dv),
        .de_flag    (wr_de),
        .ovr_flag   (wr_ovr),
        .fw_wr_valid(fw_wr_valid),
        .fw_wr_addr (fw_wr_addr),
        .fw_wr_data (fw_wr_data),
        .fw_wr_last (fw_wr_last)
    );

    mbx_rd_chan #(.TAKE_LAT(TAKE_LAT)) i_rd_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (rctl_we),
        .addr_we    (raddr_we),
        .wdata      (bus_wdata),
        .ctl_val    (rctl_val),
        .addr_val   (raddr_val),
        .data_val   (rdata_val),
        .av_flag    (rd_av),
        .dv_flag    (rd_dv),
        .de_flag    (rd_de),
        .ovr_flag   (rd_ovr),
        .fw_rd_req  (fw_rd_req),
        .fw_rd_addr (fw_rd_addr),
        .fw_rd_ready(fw_rd_ready),
        .fw_rd_valid(fw_rd_valid),
        .fw_rd_data (fw_rd_data),
        .fw_rd_last (fw_rd_last)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              fw_wr_valid,
    input logic              fw_rd_req,
    input logic              fw_rd_ready,
    input logic              fw_rd_valid,
    input logic              fw_rd_last,
    input logic              wr_av,
    input logic              wr_dv,
    input logic              wr_de,
    input logic              wr_ovr,
    input logic              rd_av,
    input logic              rd_dv,
    input logic              rd_de
);
    assert_wr_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_wr_valid |=> !fw_wr_valid);

    assert_wr_emit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_wr_valid |=> (!wr_dv && !wr_de));

    assert_no_early_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fw_wr_valid |-> (wr_dv && $past(wr_dv)));

    assert_wr_addr_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_av) |-> !fw_wr_valid);

    assert_ovr_clear_by_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_ovr) |-> $past(bus_wr && (bus_addr == ADDR_W'(8'h20)) && bus_wdata[8]));

    assert_rd_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fw_rd_req |=> (!fw_rd_req && !rd_av));

    assert_rd_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dv |-> !fw_rd_ready);

    assert_rd_beat_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_rd_valid && fw_rd_ready) |=> (rd_dv && (rd_de == $past(fw_rd_last))));
endmodule

bind csr_mailbox_ep mbx_checker #(.ADDR_W(ADDR_W)) i_mbx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .fw_wr_valid(fw_wr_valid),
    .fw_rd_req  (fw_rd_req),
    .fw_rd_ready(fw_rd_ready),
    .fw_rd_valid(fw_rd_valid),
    .fw_rd_last (fw_rd_last),
    .wr_av      (wr_av),
    .wr_dv      (wr_dv),
    .wr_de      (wr_de),
    .wr_ovr     (wr_ovr),
    .rd_av      (rd_av),
    .rd_dv      (rd_dv),
    .rd_de      (rd_de)
);

// File: tb/test_csr_mailbox_ep.sv
`timescale 1ns/1ps
module test_csr_mailbox_ep;
    localparam int unsigned AW  = 8;
    localparam int unsigned LAT = 3;

    localparam logic [7:0] A_WCTL = 8'h20, A_WADR = 8'h24, A_WDAT = 8'h28;
    localparam logic [7:0] A_RCTL = 8'h30, A_RADR = 8'h34, A_RDAT = 8'h38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fw_wr_valid, fw_wr_last, fw_rd_req, fw_rd_ready;
    logic [31:0]   fw_wr_addr, fw_wr_data, fw_rd_addr;
    logic          fw_rd_valid = 1'b0, fw_rd_last = 1'b0;
    logic [31:0]   fw_rd_data = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    csr_mailbox_ep #(.ADDR_W(AW), .TAKE_LAT(LAT)) i_csr_mailbox_ep (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fw_wr_valid(fw_wr_valid), .fw_wr_addr(fw_wr_addr), .fw_wr_data(fw_wr_data),
        .fw_wr_last(fw_wr_last), .fw_rd_req(fw_rd_req), .fw_rd_addr(fw_rd_addr),
        .fw_rd_ready(fw_rd_ready), .fw_rd_valid(fw_rd_valid), .fw_rd_data(fw_rd_data),
        .fw_rd_last(fw_rd_last)
    );

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input int b);
        return a ^ 32'hC0DE_0000 ^ (32'h0101_0101 * (b + 1));
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // firmware write-stream monitor
    int          wr_cnt = 0;
    int          wide_cnt = 0;
    bit          prev_wv = 1'b0;
    logic [31:0] mon_addr, mon_data;
    logic        mon_last;
    int          rq_cnt = 0;
    logic [31:0] rq_addr;
    always @(negedge clk) begin
        if (fw_wr_valid) begin
            wr_cnt++;
            mon_addr = fw_wr_addr;
            mon_data = fw_wr_data;
            mon_last = fw_wr_last;
            if (prev_wv) wide_cnt++;
        end
        prev_wv = fw_wr_valid;
        if (fw_rd_req) begin
            rq_cnt++;
            rq_addr = fw_rd_addr;
        end
    end

    // firmware read responder
    int          rsp_beats = 1;
    int          rsp_beat = 0;
    int          rsp_total = 1;
    logic [31:0] rsp_addr = '0;
    bit          acc_pend = 1'b0;
    always @(negedge clk) begin
        if (acc_pend) begin
            rsp_beat++;
            if (rsp_beat >= rsp_total) begin
                fw_rd_valid = 1'b0;
                fw_rd_last  = 1'b0;
            end else begin
                fw_rd_data = exp_rd(rsp_addr, rsp_beat);
                fw_rd_last = (rsp_beat == rsp_total - 1);
            end
        end
        if (fw_rd_req) begin
            rsp_addr    = fw_rd_addr;
            rsp_total   = rsp_beats;
            rsp_beat    = 0;
            fw_rd_valid = 1'b1;
            fw_rd_data  = exp_rd(fw_rd_addr, 0);
            fw_rd_last  = (rsp_beats == 1);
        end
        acc_pend = fw_rd_valid && fw_rd_ready;
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic poll(input logic [7:0] a, input logic [31:0] mask, input bit want, input string rq);
        logic [31:0] v;
        bit hit = 1'b0;
        for (int i = 0; i < 300 && !hit; i++) begin
            bus_read(a, v);
            if ((v & mask) == (want ? mask : 32'h0)) hit = 1'b1;
        end
        if (!hit) chk(1'b0, rq, v, want ? mask : 32'h0);
    endtask

    task automatic wait_wr(input int n);
        for (int i = 0; i < 200 && wr_cnt < n; i++) @(negedge clk);
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d, input bit last, input string rq);
        int n = wr_cnt;
        poll(A_WCTL, 32'h1, 1'b0, rq);
        bus_write(A_WADR, a);
        bus_write(A_WCTL, 32'h1);
        poll(A_WCTL, 32'h2, 1'b0, rq);
        poll(A_WCTL, 32'h4, 1'b0, rq);
        bus_write(A_WDAT, d);
        if (last) bus_write(A_WCTL, 32'h4);
        bus_write(A_WCTL, 32'h2);
        wait_wr(n + 1);
        chk(wr_cnt == n + 1, {rq, " R4 beat count"}, 32'(wr_cnt), 32'(n + 1));
        chk(mon_addr == a, {rq, " R3 beat address"}, mon_addr, a);
        chk(mon_data == d, {rq, " R4 beat data"}, mon_data, d);
        chk(mon_last == last, {rq, " R4 beat last"}, 32'(mon_last), 32'(last));
    endtask

    task automatic host_rd(input logic [31:0] a, input int beats, input string rq);
        logic [31:0] v;
        int n = rq_cnt;
        rsp_beats = beats;
        poll(A_RCTL, 32'h1, 1'b0, rq);
        bus_write(A_RADR, a);
        bus_write(A_RCTL, 32'h1);
        for (int b = 0; b < beats; b++) begin
            poll(A_RCTL, 32'h2, 1'b1, {rq, " R9 data-valid"});
            bus_read(A_RDAT, v);
            chk(v == exp_rd(a, b), {rq, " R9 beat data"}, v, exp_rd(a, b));
            bus_read(A_RCTL, v);
            chk(v[2] == (b == beats - 1), {rq, " R9 data-end"}, 32'(v[2]), 32'(b == beats - 1));
            bus_write(A_RCTL, 32'h6);
        end
        bus_read(A_RCTL, v);
        chk(v[2:0] == 3'b000, {rq, " R10 ack clears"}, v, 32'h0);
        chk(rq_cnt == n + 1, {rq, " R8 request count"}, 32'(rq_cnt), 32'(n + 1));
        chk(rq_addr == a, {rq, " R8 request address"}, rq_addr, a);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20250));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!fw_wr_valid && !fw_rd_req && !fw_rd_ready, "R1 strobes low", 32'({fw_wr_valid, fw_rd_req, fw_rd_ready}), 32'h0);
        bus_read(A_WCTL, v); chk(v == 32'h0, "R1 write ctl", v, 32'h0);
        bus_read(A_RCTL, v); chk(v == 32'h0, "R1 read ctl", v, 32'h0);

        // R13 / R2 decode
        bus_read(8'h00, v); chk(v == 32'h0, "R13 unmapped reads 0", v, 32'h0);
        bus_write(A_WADR, 32'h0000_1234);
        bus_read(A_WADR, v); chk(v == 32'h0000_1234, "R2 write address readback", v, 32'h0000_1234);
        bus_write(A_RADR, 32'h0000_0ABC);
        bus_read(A_RADR, v); chk(v == 32'h0000_0ABC, "R2 read address readback", v, 32'h0000_0ABC);

        // R6 writing 0 or acking clear flags
        bus_write(A_WCTL, 32'h0);
        bus_read(A_WCTL, v); chk(v == 32'h0, "R6 zero write no effect", v, 32'h0);
        bus_write(A_RCTL, 32'h6);
        bus_read(A_RCTL, v); chk(v == 32'h0, "R6 ack while clear no effect", v, 32'h0);

        // R7 write-channel overrun on address and data
        bus_write(A_WADR, 32'hAAAA_0001);
        bus_write(A_WCTL, 32'h1);
        bus_write(A_WADR, 32'hBBBB_0002);
        bus_read(A_WCTL, v); chk(v[8] == 1'b1, "R7 address overrun set", v, 32'h100);
        bus_write(A_WDAT, 32'h1111_2222);
        bus_write(A_WCTL, 32'h4);
        bus_write(A_WCTL, 32'h2);
        bus_write(A_WDAT, 32'h3333_4444);
        wait_wr(1);
        chk(mon_addr == 32'hAAAA_0001, "R7 ignored address write", mon_addr, 32'hAAAA_0001);
        chk(mon_data == 32'h1111_2222, "R7 ignored data write", mon_data, 32'h1111_2222);
        chk(mon_last == 1'b1, "R4 last flag carried", 32'(mon_last), 32'h1);
        bus_read(A_WCTL, v); chk(v == 32'h100, "R7 overrun sticky, flags cleared", v, 32'h100);
        bus_write(A_WCTL, 32'h100);
        bus_read(A_WCTL, v); chk(v == 32'h0, "R7 overrun cleared by W1", v, 32'h0);

        // R11 / R7 read channel overrun and read-only data
        rsp_beats = 1;
        bus_write(A_RADR, 32'h0000_5500);
        bus_write(A_RCTL, 32'h1);
        bus_write(A_RADR, 32'h0000_6600);
        poll(A_RCTL, 32'h2, 1'b1, "R9 data-valid");
        bus_read(A_RCTL, v); chk(v == 32'h106, "R7 read overrun and flags", v, 32'h106);
        chk(rq_addr == 32'h0000_5500, "R7 read address kept", rq_addr, 32'h0000_5500);
        bus_write(A_RDAT, 32'hDEAD_BEEF);
        bus_read(A_RDAT, v); chk(v == exp_rd(32'h5500, 0), "R11 read data not writable", v, exp_rd(32'h5500, 0));
        bus_write(A_RCTL, 32'h0);
        bus_read(A_RCTL, v); chk(v[1] == 1'b1, "R6 zero write keeps data-valid", v, 32'h106);
        bus_write(A_RCTL, 32'h6);
        bus_read(A_RCTL, v); chk(v == 32'h100, "R10 ack clears flags", v, 32'h100);
        bus_write(A_RCTL, 32'h100);
        bus_read(A_RCTL, v); chk(v == 32'h0, "R7 read overrun cleared", v, 32'h0);

        // R12 command transaction
        host_wr(32'h0, 32'h0000_0107, 1'b1, "R12 command");
        host_wr(32'h0, 32'h0000_0003, 1'b1, "R12 parameter");
        host_rd(32'h0, 1, "R12 status");

        // R10 multi-beat read
        host_rd(32'h0000_0400, 3, "R10 burst");

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [31:0] ra, rd;
            ra = $urandom;
            rd = $urandom;
            if ($urandom % 2 == 0) begin
                host_wr(ra, rd, 1'($urandom % 2), "R4 random write");
            end else begin
                host_rd(ra, 1 + int'($urandom % 3), "R9 random read");
            end
        end

        chk(wide_cnt == 0, "R4 strobe one cycle", 32'(wide_cnt), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule